// File: doc/BRIEF.md
# Codec Power-Down Sequencer

This block sets the power state of the digital section of a PCM voice codec. It samples, in the master clock domain, a power-on reset, a dual-use pin that carries either a static power-down level or a receive master clock, and the transmit and receive frame sync strobes. From these it drives a power-down flag that gates non-essential logic. It also drives two permission signals: one for the tri-state driver of the serial PCM output and one for the analog output drivers. A fourth output tells the clocking logic whether the receive side runs on its own master clock or borrows the transmit one.

The block sleeps in two cases: the dual-use pin is held statically high, or both frame syncs stay low for longer than an idle timeout. It wakes on the first frame sync rising edge once waking is allowed. The serial data output is only released from the second transmit frame sync after wake-up. Every output comes from a register, and the inputs are treated as already synchronous to the master clock.

Top module: `codec_pwr_seq`

## Requirements
- R1: While `por_n` is low and on the first cycle after it rises, `pwr_down` is 1 and `dx_en_ok`, `vout_en_ok` and `rx_own_mclk` are 0.
- R2: The pin is static high when no change of `pdn_pin` has been registered within the last `DETECT_WINDOW` cycles and its registered level is 1. In that case the block is powered down at the next clock edge and stays powered down.
- R3: Any cycle that samples `fsx` or `fsr` high reloads the idle timer. If neither is sampled high for `IDLE_TIMEOUT` further edges, `pwr_down` rises at the edge after those, which is edge `IDLE_TIMEOUT`+1 counted from the last edge that sampled a sync high.
- R4: Waking is allowed while a pin clock is registered as present or the registered pin level is 0. While powered down and allowed to wake, an edge that samples a frame sync high (either direction) whose previous sample was low clears `pwr_down` at that same edge.
- R5: `dx_en_ok` is 1 only when powered up and at least two `fsx` rising edges have been counted since the wake-up. A wake-up caused by an `fsx` rise counts as the first. The count saturates at 2 and clears on power-down.
- R6: `rx_own_mclk` is 1 when a change of `pdn_pin` was registered within the last `DETECT_WINDOW` cycles. It returns to 0 once the pin holds one level for that window, meaning the receive side borrows the transmit master clock.
- R7: `vout_en_ok` is 1 exactly when `pwr_down` is 0.
- R8: Frame sync rising edges do not wake the block while the pin is statically high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit master clock, samples every input |
| por_n | input | 1 | Power-on reset, active low |
| pdn_pin | input | 1 | Dual-use pin: static power-down level or receive master clock |
| fsx | input | 1 | Transmit frame sync strobe |
| fsr | input | 1 | Receive frame sync strobe |
| pwr_down | output | 1 | 1 while non-essential logic is held off |
| dx_en_ok | output | 1 | Permission to enable the serial PCM output driver |
| vout_en_ok | output | 1 | Permission to enable the analog output drivers |
| rx_own_mclk | output | 1 | 1: receive uses its own master clock; 0: borrow transmit clock |

## Verification
The assertions check on every cycle that the data output permission never appears while powered down. They also check that every wake-up is preceded by a frame sync rise, that a registered static-high pin is followed by power-down, that a clock-present declaration follows a pin change, and that the frame counter and idle timer stay in range. The exact timeout edge, the wake-up edge, the release of the data output at the second transmit sync, and the detector window length can only be shown by the bench scenarios. Those scenarios compare all four outputs each cycle against a model built from the requirements, under static-low, static-high, toggling-pin and idle stretches.

// File: rtl/cps_pkg.sv
package cps_pkg;
   typedef enum logic {
      PS_DOWN = 1'b0,
      PS_UP   = 1'b1
   } pwr_state_t;

   localparam int unsigned TX_RELEASE_COUNT = 2;
endpackage

// File: rtl/cps_pin_detect.sv
module cps_pin_detect #(
   parameter int unsigned DETECT_WINDOW = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic clk_present,
   output logic pin_level,
   output logic wake_allowed,
   output logic force_down
);
   localparam int unsigned CW = (DETECT_WINDOW > 2) ? $clog2(DETECT_WINDOW) : 1;
   localparam logic [CW-1:0] LAST = CW'(DETECT_WINDOW - 1);

   generate
      if (DETECT_WINDOW < 2) begin : g_bad_window
         $error("DETECT_WINDOW must be at least 2");
      end
   endgenerate

   logic          pin_q;
   logic [CW-1:0] quiet_cnt;
   logic          present_q;
   logic          pin_changed;

   assign pin_changed = pin_in ^ pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q     <= 1'b1;
         quiet_cnt <= '0;
         present_q <= 1'b0;
      end else begin
         pin_q <= pin_in;
         if (pin_changed) begin
            present_q <= 1'b1;
            quiet_cnt <= '0;
         end else if (quiet_cnt < LAST) begin
            quiet_cnt <= quiet_cnt + 1'b1;
         end else begin
            present_q <= 1'b0;
         end
      end
   end

   assign clk_present  = present_q;
   assign pin_level    = pin_q;
   assign wake_allowed = present_q | ~pin_q;
   assign force_down   = ~present_q & pin_q;

   AST_CLK_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(present_q) |-> $past(pin_changed)); // R6
   AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      quiet_cnt <= LAST); // R6
endmodule

// File: rtl/cps_idle_timer.sv
module cps_idle_timer #(
   parameter int unsigned IDLE_TIMEOUT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fsx,
   input  logic fsr,
   output logic fsx_rise,
   output logic fsr_rise,
   output logic expired
);
   localparam int unsigned TW = $clog2(IDLE_TIMEOUT + 1);
   localparam logic [TW-1:0] LIMIT = TW'(IDLE_TIMEOUT);

   generate
      if (IDLE_TIMEOUT < 2) begin : g_bad_timeout
         $error("IDLE_TIMEOUT must be at least 2");
      end
   endgenerate

   logic          fsx_q, fsr_q;
   logic [TW-1:0] idle_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsx_q    <= 1'b0;
         fsr_q    <= 1'b0;
         idle_cnt <= LIMIT;
      end else begin
         fsx_q <= fsx;
         fsr_q <= fsr;
         if (fsx | fsr) begin
            idle_cnt <= '0;
         end else if (idle_cnt != LIMIT) begin
            idle_cnt <= idle_cnt + 1'b1;
         end
      end
   end

   assign fsx_rise = fsx & ~fsx_q;
   assign fsr_rise = fsr & ~fsr_q;
   assign expired  = (idle_cnt == LIMIT);

   AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      idle_cnt <= LIMIT); // R3
   AST_RELOAD_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (fsx | fsr) |=> !expired); // R3
endmodule

// File: rtl/cps_state_ctl.sv
module cps_state_ctl
   import cps_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wake_allowed,
   input  logic force_down,
   input  logic idle_expired,
   input  logic fsx_rise,
   input  logic fsr_rise,
   output logic pwr_down,
   output logic dx_en_ok,
   output logic vout_en_ok
);
   pwr_state_t state_q;
   logic [1:0] txcnt_q;
   logic       any_rise;
   logic       go_up, go_down;

   assign any_rise = fsx_rise | fsr_rise;
   assign go_up    = (state_q == PS_DOWN) & wake_allowed & any_rise;
   assign go_down  = (state_q == PS_UP) & (force_down | (idle_expired & ~any_rise));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_DOWN;
         txcnt_q <= '0;
      end else begin
         if (state_q == PS_DOWN) begin
            if (go_up) begin
               state_q <= PS_UP;
               txcnt_q <= fsx_rise ? 2'd1 : 2'd0;
            end else begin
               txcnt_q <= '0;
            end
         end else if (go_down) begin
            state_q <= PS_DOWN;
            txcnt_q <= '0;
         end else if (fsx_rise && txcnt_q < 2'(TX_RELEASE_COUNT)) begin
            txcnt_q <= txcnt_q + 1'b1;
         end
      end
   end

   assign pwr_down   = (state_q == PS_DOWN);
   assign vout_en_ok = (state_q == PS_UP);
   assign dx_en_ok   = (state_q == PS_UP) && (txcnt_q == 2'(TX_RELEASE_COUNT));

   AST_DX_ONLY_WHEN_UP: assert property (@(posedge clk) disable iff (!rst_n)
      dx_en_ok |-> !pwr_down); // R5
   AST_TXCNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      txcnt_q <= 2'(TX_RELEASE_COUNT)); // R5
   AST_WAKE_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_down) |-> $past(any_rise)); // R4
   AST_STATIC_HIGH_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      force_down |=> pwr_down); // R2
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq #(
   parameter int unsigned IDLE_TIMEOUT  = 4096,
   parameter int unsigned DETECT_WINDOW = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic pdn_pin,
   input  logic fsx,
   input  logic fsr,
   output logic pwr_down,
   output logic dx_en_ok,
   output logic vout_en_ok,
   output logic rx_own_mclk
);
   logic clk_present, pin_level, wake_allowed, force_down;
   logic fsx_rise, fsr_rise, idle_expired;

   cps_pin_detect #(.DETECT_WINDOW(DETECT_WINDOW)) u_pin (
      .clk          (clk),
      .rst_n        (por_n),
      .pin_in       (pdn_pin),
      .clk_present  (clk_present),
      .pin_level    (pin_level),
      .wake_allowed (wake_allowed),
      .force_down   (force_down)
   );

   cps_idle_timer #(.IDLE_TIMEOUT(IDLE_TIMEOUT)) u_tmr (
      .clk      (clk),
      .rst_n    (por_n),
      .fsx      (fsx),
      .fsr      (fsr),
      .fsx_rise (fsx_rise),
      .fsr_rise (fsr_rise),
      .expired  (idle_expired)
   );

   cps_state_ctl u_ctl (
      .clk          (clk),
      .rst_n        (por_n),
      .wake_allowed (wake_allowed),
      .force_down   (force_down),
      .idle_expired (idle_expired),
      .fsx_rise     (fsx_rise),
      .fsr_rise     (fsr_rise),
      .pwr_down     (pwr_down),
      .dx_en_ok     (dx_en_ok),
      .vout_en_ok   (vout_en_ok)
   );

   assign rx_own_mclk = clk_present;

   AST_VOUT_OFF_WHEN_DOWN: assert property (@(posedge clk) disable iff (!por_n)
      pwr_down |-> (!vout_en_ok && !dx_en_ok)); // R7
   AST_NO_WAKE_STATIC_HIGH: assert property (@(posedge clk) disable iff (!por_n)
      (pwr_down && pin_level && !clk_present) |=> pwr_down); // R8
endmodule

// File: tb/codec_pwr_seq_tb.sv
module codec_pwr_seq_tb;
   localparam int unsigned T = 40;
   localparam int unsigned W = 8;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic pdn_pin = 1'b1;
   logic fsx = 1'b0;
   logic fsr = 1'b0;
   logic pwr_down, dx_en_ok, vout_en_ok, rx_own_mclk;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   // reference model state, built from the requirements
   bit m_pin_q, m_clk, m_fsx_q, m_fsr_q, m_up;
   int m_cnt, m_tmr, m_tx;

   always #5 clk = ~clk;

   codec_pwr_seq #(.IDLE_TIMEOUT(T), .DETECT_WINDOW(W)) u_dut (
      .clk(clk), .por_n(por_n), .pdn_pin(pdn_pin), .fsx(fsx), .fsr(fsr),
      .pwr_down(pwr_down), .dx_en_ok(dx_en_ok),
      .vout_en_ok(vout_en_ok), .rx_own_mclk(rx_own_mclk)
   );

   function automatic bit exp_dx(bit up, int tx);
      return up && (tx >= 2);
   endfunction

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!por_n) begin
         m_pin_q = 1'b1; m_clk = 1'b0; m_cnt = 0;
         m_fsx_q = 1'b0; m_fsr_q = 1'b0; m_tmr = T;
         m_up = 1'b0; m_tx = 0;
      end else begin
         bit rx, rr, wake, permit, force_dn, expd;
         rx = fsx & !m_fsx_q;
         rr = fsr & !m_fsr_q;
         wake = rx | rr;
         permit = m_clk | !m_pin_q;
         force_dn = !m_clk & m_pin_q;
         expd = (m_tmr == T);
         if (!m_up) begin
            if (permit && wake) begin m_up = 1'b1; m_tx = rx ? 1 : 0; end
            else m_tx = 0;
         end else if (force_dn || (expd && !wake)) begin
            m_up = 1'b0; m_tx = 0;
         end else if (rx && m_tx < 2) begin
            m_tx = m_tx + 1;
         end
         if (fsx | fsr) m_tmr = 0;
         else if (m_tmr < T) m_tmr = m_tmr + 1;
         if (pdn_pin != m_pin_q) begin m_clk = 1'b1; m_cnt = 0; end
         else if (m_cnt < W - 1) m_cnt = m_cnt + 1;
         else m_clk = 1'b0;
         m_pin_q = pdn_pin;
         m_fsx_q = fsx;
         m_fsr_q = fsr;
      end
   end

   task automatic chk(string req, string what, bit act, bit exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   task automatic check_all();
      chk("R2/R3/R4", "pwr_down", pwr_down, !m_up);
      chk("R7", "vout_en_ok", vout_en_ok, m_up);
      chk("R5", "dx_en_ok", dx_en_ok, exp_dx(m_up, m_tx));
      chk("R6", "rx_own_mclk", rx_own_mclk, m_clk);
   endtask

   task automatic cyc(bit p, bit x, bit r);
      @(negedge clk);
      if (por_n) check_all();
      pdn_pin = p; fsx = x; fsr = r;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      if (cycles > 100000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      void'($urandom(1234));
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "pwr_down in reset", pwr_down, 1'b1);
      chk("R1", "dx_en_ok in reset", dx_en_ok, 1'b0);
      chk("R1", "vout_en_ok in reset", vout_en_ok, 1'b0);
      chk("R1", "rx_own_mclk in reset", rx_own_mclk, 1'b0);
      por_n = 1'b1;
      @(negedge clk);
      chk("R1", "pwr_down after release", pwr_down, 1'b1);
      chk("R1", "vout_en_ok after release", vout_en_ok, 1'b0);

      // R8: syncs while pin static high must not wake
      for (int i = 0; i < 40; i++) cyc(1'b1, (i % 10) == 0, (i % 10) == 5);
      @(negedge clk);
      chk("R8", "no wake with static high", pwr_down, 1'b1);

      // R4/R5: pin low, wake via fsr, then fsx frames
      for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 1'b1);
      cyc(1'b0, 1'b0, 1'b0);
      chk("R4", "woke on fsr rise", pwr_down, 1'b0);
      for (int i = 0; i < 12; i++) cyc(1'b0, i == 2, 1'b0);
      chk("R5", "dx held after first fsx", dx_en_ok, 1'b0);
      for (int i = 0; i < 12; i++) cyc(1'b0, i == 2 || i == 3 || i == 4, 1'b0);
      chk("R5", "dx released after second fsx", dx_en_ok, 1'b1);

      // R3: idle timeout
      for (int i = 0; i < int'(T) + 4; i++) cyc(1'b0, 1'b0, 1'b0);
      chk("R3", "down after idle timeout", pwr_down, 1'b1);

      // R6/R2: clock on pin, then static high
      for (int i = 0; i < 30; i++) cyc(i[0], (i % 12) == 3, 1'b0);
      chk("R6", "clock detected", rx_own_mclk, 1'b1);
      for (int i = 0; i < int'(W) + 4; i++) cyc(1'b1, (i % 12) == 3, 1'b0);
      chk("R2", "down on static high", pwr_down, 1'b1);
      chk("R6", "borrow when static", rx_own_mclk, 1'b0);

      // constrained random segments
      for (int s = 0; s < 60; s++) begin
         int mode, len, per, wid, off, half;
         bit idle, rx_on, p;
         mode = $urandom % 3;
         len = 40 + ($urandom % 80);
         per = 8 + ($urandom % 12);
         wid = ($urandom % 2) ? 1 : 3;
         off = $urandom % per;
         half = 1 + ($urandom % 3);
         idle = ($urandom % 4) == 0;
         rx_on = ($urandom % 2) == 1;
         for (int i = 0; i < len; i++) begin
            p = (mode == 1) ? 1'b1 : (mode == 2) ? bit'((i / half) % 2) : 1'b0;
            cyc(p, !idle && ((i % per) < wid),
                !idle && rx_on && (((i + off) % per) < wid));
         end
      end
      @(negedge clk);
      check_all();
      finish_run();
   end
endmodule